// File: doc/BRIEF.md
# Lane Exchange Network

This block moves 32-bit values between the lanes of a 32-lane group in one step. Every lane presents a value. On a start strobe one operation, shared by all lanes, picks for each lane a source lane inside the same subgroup, and the lane receives that source's value. There are four ways to name the source: an absolute index, a fixed distance toward lower lanes, a fixed distance toward higher lanes, or a bitwise XOR of the lane's own position.

A width operand cuts the group into consecutive power-of-two subgroups. Each subgroup runs the exchange on its own, with positions counted from 0 at its first lane. A per-lane active mask lets idle lanes keep their own value. The result is registered and comes out one cycle after the strobe, together with a single-cycle valid pulse and an error flag for an illegal width.

Top module: `lane_xchg`

## Requirements
- R1: With op_i = 0 (indexed), each lane gets the value of lane base + (lane_opnd_i mod width), where base is the first lane of the caller's subgroup.
- R2: With op_i = 1 (shift toward lower lanes), lane at subgroup position p gets the value of position p - lane_opnd_i. If that position is below 0, the lane keeps its own input.
- R3: With op_i = 2 (shift toward higher lanes), lane at position p gets position p + lane_opnd_i. If that position is width or more, the lane keeps its own input.
- R4: With op_i = 3 (XOR), lane at position p gets position (p XOR lane_opnd_i) mod width of its own subgroup.
- R5: Subgroups are consecutive runs of width_i lanes, for width_i in {1,2,4,8,16,32}. No lane ever reads from outside its own subgroup.
- R6: A width_i of 0, above 32, or not a power of two sets err_o with the result, and every lane's output equals its own input.
- R7: A lane whose active_i bit is 0 outputs its own input value. A lane reading an inactive source gets an unspecified value.
- R8: data_o and err_o update on the clock edge that samples start_i high, and valid_o is high for exactly that following cycle. Without start_i, data_o and err_o hold.
- R9: After reset, valid_o, err_o and data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an exchange with the current operands |
| op_i | input | 2 | 0 indexed, 1 shift lower, 2 shift higher, 3 XOR |
| lane_opnd_i | input | 5 | Source index, shift distance or XOR mask |
| width_i | input | 6 | Subgroup size, a power of two from 1 to 32 |
| active_i | input | 32 | One bit per lane, 1 = lane takes part |
| data_i | input | 1024 | Lane values, lane n at bits 32n+31 down to 32n |
| data_o | output | 1024 | Registered exchanged values, same packing |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| err_o | output | 1 | Illegal width seen with the current result |

## Verification
A wrong source computation shows up directly as a misplaced lane value in data_o, in the cycle right after the strobe. The scoreboard compares every lane whose source is defined against a model built from lane arithmetic. A subgroup mask derived wrongly from the width shows up as values crossing subgroup boundaries or failing to wrap. Mishandled edges of the shift modes show up as a lane taking a neighbour's value instead of keeping its own. Bad strobe timing shows up as a valid pulse with no pending expectation or data changing between operations, and both are caught within a cycle.

// File: rtl/lx_pkg.sv
package lx_pkg;
  typedef enum logic [1:0] {
    OP_IDX  = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_XOR  = 2'd3
  } lx_op_e;
endpackage

// File: rtl/lx_width_chk.sv
module lx_width_chk #(
  parameter int LANES = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LW:0]   width_i,
  output logic          ok_o,
  output logic [LW-1:0] seg_mask_o
);
  logic [LW:0] wm1;

  always_comb begin
    wm1        = width_i - 1'b1;
    seg_mask_o = wm1[LW-1:0];
    ok_o       = (width_i != '0) && (width_i <= (LW+1)'(LANES)) &&
                 ((width_i & wm1) == '0);
  end
endmodule

// File: rtl/lx_src_sel.sv
module lx_src_sel
  import lx_pkg::*;
#(
  parameter int LANES = 32,
  parameter int LANE  = 0,
  localparam int LW = $clog2(LANES)
) (
  input  lx_op_e        op_i,
  input  logic [LW-1:0] opnd_i,
  input  logic [LW-1:0] seg_mask_i,
  output logic [LW-1:0] src_o,
  output logic          keep_o
);
  localparam logic [LW-1:0] SELF = LW'(LANE);

  logic [LW-1:0] base, off;
  logic [LW:0]   fwd;

  always_comb begin
    base   = SELF & ~seg_mask_i;
    off    = SELF & seg_mask_i;
    fwd    = {1'b0, off} + {1'b0, opnd_i};
    src_o  = SELF;
    keep_o = 1'b0;
    unique case (op_i)
      OP_IDX:  src_o = base | (opnd_i & seg_mask_i);
      OP_UP: begin
        // position below 0 keeps own value
        if (off >= opnd_i) src_o = SELF - opnd_i;
        else               keep_o = 1'b1;
      end
      OP_DOWN: begin
        if (fwd <= {1'b0, seg_mask_i}) src_o = SELF + opnd_i;
        else                           keep_o = 1'b1;
      end
      OP_XOR:  src_o = base | ((off ^ opnd_i) & seg_mask_i);
      default: keep_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lx_xbar.sv
module lx_xbar #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] data_i,
  input  logic [LANES*LW-1:0] src_i,
  output logic [LANES*DW-1:0] data_o
);
  logic [DW-1:0] lane_val [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_val[g]        = data_i[g*DW +: DW];
    assign data_o[g*DW +: DW] = lane_val[src_i[g*LW +: LW]];
  end
endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
  import lx_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [LW-1:0]       lane_opnd_i,
  input  logic [LW:0]         width_i,
  input  logic [LANES-1:0]    active_i,
  input  logic [LANES*DW-1:0] data_i,
  output logic [LANES*DW-1:0] data_o,
  output logic                valid_o,
  output logic                err_o
);
  logic                width_ok;
  logic [LW-1:0]       seg_mask;
  logic [LANES*LW-1:0] src_vec;
  logic [LANES-1:0]    keep_vec;
  logic [LANES*DW-1:0] moved;
  logic [LANES*DW-1:0] result;
  lx_op_e              op;

  assign op = lx_op_e'(op_i);

  lx_width_chk #(.LANES(LANES)) u_wchk (
    .width_i    (width_i),
    .ok_o       (width_ok),
    .seg_mask_o (seg_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    lx_src_sel #(.LANES(LANES), .LANE(g)) u_sel (
      .op_i       (op),
      .opnd_i     (lane_opnd_i),
      .seg_mask_i (seg_mask),
      .src_o      (src_vec[g*LW +: LW]),
      .keep_o     (keep_vec[g])
    );
  end

  lx_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
    .data_i (data_i),
    .src_i  (src_vec),
    .data_o (moved)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_res
    // own value on illegal width, inactive lane or out-of-range shift
    assign result[g*DW +: DW] = (!width_ok || !active_i[g] || keep_vec[g]) ?
                                data_i[g*DW +: DW] : moved[g*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        data_o <= result;
        err_o  <= !width_ok;
      end
    end
  end
endmodule

// File: rtl/lx_checker.sv
module lx_checker #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [LANES-1:0]    active_i,
  input logic [LANES*DW-1:0] data_i,
  input logic [LANES*DW-1:0] data_o,
  input logic                valid_o,
  input logic                err_o
);
  a_r8_valid_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(data_o) && $stable(err_o)));
  a_r6_err_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o || $stable(err_o));
  a_r6_err_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i ##1 err_o) |-> data_o == $past(data_i));

  for (genvar g = 0; g < LANES; g++) begin : g_act
    a_r7_inactive_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !active_i[g]) |=> data_o[g*DW +: DW] == $past(data_i[g*DW +: DW]));
  end
endmodule

bind lane_xchg lx_checker #(.LANES(LANES), .DW(DW)) u_lx_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .active_i (active_i),
  .data_i   (data_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .err_o    (err_o)
);

// File: tb/tb_lane_xchg.sv
`timescale 1ns/1ps
module tb_lane_xchg;
  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int LW    = 5;

  typedef struct packed {
    logic [LANES*DW-1:0] data;
    logic [LANES-1:0]    care;
    logic                err;
    logic [3:0]          req;
  } exp_t;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [1:0]          op_i = '0;
  logic [LW-1:0]       lane_opnd_i = '0;
  logic [LW:0]         width_i = 6'd32;
  logic [LANES-1:0]    active_i = '1;
  logic [LANES*DW-1:0] data_i = '0;
  logic [LANES*DW-1:0] data_o;
  logic                valid_o;
  logic                err_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   n_pop = 0;
  int   n_push = 0;
  exp_t q[$];
  logic [LANES*DW-1:0] last_data;

  always #2.5 clk_i = ~clk_i;

  lane_xchg #(.LANES(LANES), .DW(DW)) dut (.*);

  function automatic exp_t model(input int op, input int opnd, input int w,
                                 input logic [LANES-1:0] act,
                                 input logic [LANES*DW-1:0] din, input int req);
    exp_t e;
    bit   ok;
    ok = (w >= 1) && (w <= LANES) && ((w & (w - 1)) == 0);
    e.req = 4'(req);
    e.err = !ok;
    e.care = '1;
    e.data = din;
    if (ok) begin
      for (int i = 0; i < LANES; i++) begin
        int base, pos, src;
        base = (i / w) * w;
        pos  = i % w;
        src  = -1;
        case (op)
          0: src = base + (opnd % w);
          1: if (pos - opnd >= 0) src = i - opnd;
          2: if (pos + opnd < w) src = i + opnd;
          default: src = base + ((pos ^ opnd) % w);
        endcase
        if (act[i] && src >= 0) begin
          if (act[src]) e.data[i*DW +: DW] = din[src*DW +: DW];
          else          e.care[i] = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input int op, input int opnd, input int w,
                       input logic [LANES-1:0] act, input int req);
    logic [LANES*DW-1:0] d;
    @(negedge clk_i);
    for (int i = 0; i < LANES; i++) d[i*DW +: DW] = {8'(i), 24'($urandom)};
    op_i = 2'(op); lane_opnd_i = LW'(opnd); width_i = (LW+1)'(w);
    active_i = act; data_i = d; start_i = 1'b1;
    q.push_back(model(op, opnd, w, act, d, req));
    n_push++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act_v,
                       input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 valid without pending op", 64'(valid_o), 64'd0);
      end else begin
        exp_t e;
        int   lane_bad;
        e = q.pop_front();
        n_pop++;
        lane_bad = -1;
        for (int i = 0; i < LANES; i++)
          if (e.care[i] && data_o[i*DW +: DW] !== e.data[i*DW +: DW] && lane_bad < 0)
            lane_bad = i;
        if (lane_bad >= 0)
          check(1'b0, $sformatf("R%0d lane %0d", e.req, lane_bad),
                64'(data_o[lane_bad*DW +: DW]), 64'(e.data[lane_bad*DW +: DW]));
        else
          check(1'b1, "", 0, 0);
        check(err_o === e.err, $sformatf("R%0d err flag", e.req), 64'(err_o), 64'(e.err));
        last_data = data_o;
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [LANES-1:0] amix;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(valid_o === 1'b0 && err_o === 1'b0 && data_o === '0, "R9 reset",
          {62'd0, valid_o, err_o}, 64'd0);
    rst_ni = 1'b1;
    idle(2);

    drive(0, 5, 32, '1, 1);   idle(1);  // R1 full group
    drive(0, 11, 8, '1, 1);   idle(1);  // R1 index wraps modulo width
    drive(1, 1, 32, '1, 2);   idle(1);  // R2
    drive(1, 3, 4, '1, 2);    idle(1);  // R2 lanes below 0 keep own
    drive(1, 20, 8, '1, 2);   idle(1);  // R2 delta beyond width: all keep
    drive(2, 5, 16, '1, 3);   idle(1);  // R3
    drive(2, 0, 32, '1, 3);   idle(1);  // R3 zero delta
    drive(2, 31, 32, '1, 3);  idle(1);  // R3 only lane 0 moves
    drive(3, 1, 32, '1, 4);   idle(1);  // R4
    drive(3, 31, 8, '1, 4);   idle(1);  // R4 mask bits above width ignored
    drive(0, 7, 1, '1, 5);    idle(1);  // R5 width 1
    drive(3, 3, 2, '1, 5);    idle(1);  // R5 width 2
    drive(0, 0, 0, '1, 6);    idle(1);  // R6 zero width
    drive(0, 1, 33, '1, 6);   idle(1);  // R6 above group
    drive(1, 1, 12, '1, 6);   idle(1);  // R6 not power of two
    drive(0, 2, 4, 32'h5A5A_0F0F, 7); idle(1); // R7
    drive(3, 5, 32, 32'h0000_FFFF, 7); idle(1); // R7
    // R8 back-to-back strobes
    drive(0, 3, 16, '1, 8);
    drive(2, 2, 4, '1, 8);
    drive(3, 6, 8, '1, 8);
    idle(4);
    // R8 outputs hold while idle
    check(valid_o === 1'b0, "R8 valid low when idle", 64'(valid_o), 64'd0);
    check(data_o === last_data, "R8 data holds", data_o[63:0], last_data[63:0]);
    idle(3);
    check(data_o === last_data, "R8 data holds later", data_o[63:0], last_data[63:0]);
    // mixed sweep across all modes and legal widths
    for (int k = 0; k < 60; k++) begin
      int w;
      w = 1 << (k % 6);
      amix = (k % 3 == 0) ? LANES'($urandom) : '1;
      drive(k % 4, int'($urandom % 32), w, amix, (k % 4) + 1);
      if (k % 2 == 0) idle(1);
    end
    idle(4);
    check(q.size() == 0 && n_pop == n_push, "R8 every strobe answered",
          64'(n_pop), 64'(n_push));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule